// File: doc/BRIEF.md
# Compressibility-Aware Set Replacement Controller

This block keeps the bookkeeping for a single set of a cache whose data store holds compressed and uncompressed lines side by side. The set has `2*NSLOT` tag entries under one full recency order, but only `NSLOT` physical data slots. Each slot is two halves. A compressed line occupies one half, and an uncompressed line occupies two halves, which need not sit in the same slot. The set therefore holds anywhere from `NSLOT` to `2*NSLOT` live lines.

A lookup port compares a tag against every live entry in the same cycle. It reports hit and compressed status, and a hit promotes the entry to most-recent at the next edge. A fill request carries the new tag and a flag telling whether the line compressed to half size. One cycle later the controller reports the fill result: up to two evicted tags, the half indices assigned to the new line, and a slot action of none, split or merge. The data path follows this action to move or reinterpret storage.

Unused tag entries always gather at the least-recent end of the order. They are taken before any live line is evicted, as long as enough free halves exist.

Top module: `cmp_set_repl`

## Requirements
- R1: After reset every tag entry is empty: every lookup misses and `fill_done` is 0.
- R2: `lk_hit` and `lk_cmp` follow `lk_tag` in the same cycle. A hit with `lk_en` high makes that entry the most recent at the next edge.
- R3: `fill_done` is 1 exactly in the cycle after a cycle with `fill_en` high. All fill result outputs change at that same edge and hold until the next fill.
- R4: When the free halves cover the new line (1 for compressed, 2 for uncompressed), nothing is evicted and `slot_act` is 0 (none). `fill_h0` is the lowest free half index, and for an uncompressed line `fill_h1` is the second lowest. Half index = 2*slot + side.
- R5: When the new line and the least-recent live line have the same compressed status and storage is short, only that least-recent line is evicted. Its halves go to the new line (`fill_h0` = its first half, `fill_h1` = its second), and `slot_act` is 0.
- R6: A compressed fill whose least-recent live line is uncompressed evicts that line and splits its storage. `slot_act` is 1, and `fill_h0` is the evicted line's first half. The other half becomes free and stays empty.
- R7: An uncompressed fill that finds a compressed least-recent line and an uncompressed second-least-recent line, with no free half, evicts only the second one. `fill_h0`/`fill_h1` are that line's halves, `slot_act` is 0, and the least-recent line stays resident.
- R8: An uncompressed fill whose two least-recent lines are both compressed, with no free half, evicts both. `ev0_tag` is the least-recent one and `ev1_tag` the second. `slot_act` is 2 (merge), `fill_h0` is the least-recent line's half and `fill_h1` the other's.
- R9: An uncompressed fill with exactly one free half and a compressed least-recent line evicts only that line. `slot_act` is 2, `fill_h0` is the free half and `fill_h1` is the evicted line's half.
- R10: A lookup in the same cycle as a fill has no effect on the recency order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_en | input | 1 | Lookup request; a hit updates recency |
| lk_tag | input | TAG_W | Tag to look up |
| lk_hit | output | 1 | Tag is resident (combinational) |
| lk_cmp | output | 1 | Resident line is compressed (combinational) |
| fill_en | input | 1 | Fill request for a missing tag |
| fill_tag | input | TAG_W | Tag of the new line |
| fill_cmp | input | 1 | New line fits in one half |
| fill_done | output | 1 | Fill result valid this cycle |
| ev0_vld | output | 1 | First evicted tag valid |
| ev0_tag | output | TAG_W | First evicted tag |
| ev1_vld | output | 1 | Second evicted tag valid |
| ev1_tag | output | TAG_W | Second evicted tag |
| slot_act | output | 2 | 0 none, 1 split, 2 merge |
| fill_h0 | output | log2(2*NSLOT) | First half given to the new line |
| fill_h1 | output | log2(2*NSLOT) | Second half (uncompressed fill only) |

## Verification
Lookup results are combinational, so the bench drives a lookup on a falling edge and reads `lk_hit`/`lk_cmp` one time step later in the same cycle. It reads recency effects only through the evictions that later fills report. Fill results come from a single register stage: the bench raises `fill_en` on a falling edge and reads every result field at the next falling edge, after exactly one rising edge. It then confirms that `fill_done` has dropped one cycle later. Each scenario builds a known recency and half-occupancy picture, so the choice among replace, split, merge and second-line eviction is forced and the expected tags and half indices are fixed in advance.

// File: rtl/cmp_set_repl_pkg.sv
// Shared encodings for the compressibility-aware set replacement controller.
package cmp_set_repl_pkg;
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_SPLIT = 2'd1,
        ACT_MERGE = 2'd2
    } slot_act_e;
endpackage

// File: rtl/csr_tag_match.sv
// Parallel tag compare across all entries of the set.
// Assumes at most one valid entry carries any given tag.
module csr_tag_match #(
    parameter int NTAG = 8,
    parameter int TW   = 12,
    parameter int PW   = 3
) (
    input  logic [NTAG-1:0]         vld,
    input  logic [NTAG-1:0][TW-1:0] tags,
    input  logic [TW-1:0]           key,
    output logic                    hit,
    output logic [PW-1:0]           pos
);
    // Encode the matching position; any match raises hit.
    always_comb begin
        hit = 1'b0;
        pos = '0;
        for (int i = 0; i < NTAG; i++) begin
            if (vld[i] && tags[i] == key) begin
                hit = 1'b1;
                pos = i[PW-1:0];
            end
        end
    end
endmodule

// File: rtl/csr_free_pick.sv
// Finds the count and the two lowest indices of free halves.
// Assumes callers only use lo2 when at least two halves are free.
module csr_free_pick #(
    parameter int NHALF = 8,
    parameter int HW    = 3
) (
    input  logic [NHALF-1:0] used,
    output logic [HW:0]      fcnt,
    output logic [HW-1:0]    lo,
    output logic [HW-1:0]    lo2
);
    // Scan from the top so the last two free halves seen are the lowest.
    always_comb begin
        fcnt = '0;
        lo   = '0;
        lo2  = '0;
        for (int i = NHALF - 1; i >= 0; i--) begin
            if (!used[i]) begin
                fcnt = fcnt + 1'b1;
                lo2  = lo;
                lo   = i[HW-1:0];
            end
        end
    end
endmodule

// File: rtl/csr_order_update.sv
// Rebuilds the recency list: drops up to two positions, optionally pushes a
// word at the most-recent end, and pads the least-recent end with zero (empty).
// Assumes the caller never pushes into a list that has no room after removal.
module csr_order_update #(
    parameter int NTAG = 8,
    parameter int EW   = 20,
    parameter int PW   = 3
) (
    input  logic [NTAG-1:0][EW-1:0] cur,
    input  logic                    rm_a_en,
    input  logic [PW-1:0]           rm_a,
    input  logic                    rm_b_en,
    input  logic [PW-1:0]           rm_b,
    input  logic                    push_en,
    input  logic [EW-1:0]           push_word,
    output logic [NTAG-1:0][EW-1:0] nxt
);
    localparam logic [PW:0] NT = NTAG[PW:0];

    logic [PW:0] k;

    // Compact surviving entries behind the optional new head.
    always_comb begin
        nxt = '0;
        k   = '0;
        if (push_en) begin
            nxt[0] = push_word;
            k      = 1;
        end
        for (int i = 0; i < NTAG; i++) begin
            if (!(rm_a_en && rm_a == i[PW-1:0]) && !(rm_b_en && rm_b == i[PW-1:0])) begin
                if (k < NT) nxt[k[PW-1:0]] = cur[i];
                k = k + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmp_set_repl.sv
// Replacement controller for one cache set with 2*NSLOT tags and NSLOT data
// slots of two halves each. Compressed lines take one half, uncompressed two.
// Decides evictions and split/merge actions on fills; results are registered
// one cycle after the fill request. Assumes fills are only issued for tags
// that miss, and NSLOT >= 2.
module cmp_set_repl
    import cmp_set_repl_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int TAG_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          lk_en,
    input  logic [TAG_W-1:0]              lk_tag,
    output logic                          lk_hit,
    output logic                          lk_cmp,
    input  logic                          fill_en,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic                          fill_cmp,
    output logic                          fill_done,
    output logic                          ev0_vld,
    output logic [TAG_W-1:0]              ev0_tag,
    output logic                          ev1_vld,
    output logic [TAG_W-1:0]              ev1_tag,
    output logic [1:0]                    slot_act,
    output logic [$clog2(2*NSLOT)-1:0]    fill_h0,
    output logic [$clog2(2*NSLOT)-1:0]    fill_h1
);
    localparam int NTAG  = 2 * NSLOT;
    localparam int NHALF = 2 * NSLOT;
    localparam int HW    = $clog2(NHALF);
    localparam int PW    = $clog2(NTAG);
    localparam int EW    = 2 + TAG_W + 2 * HW;
    localparam int V_B   = EW - 1;
    localparam int C_B   = EW - 2;
    localparam int T_HI  = EW - 3;
    localparam int T_LO  = 2 * HW;

    logic [NTAG-1:0][EW-1:0]    lst, nxt_lst;
    logic [NTAG-1:0]            vld, cmpv;
    logic [NTAG-1:0][TAG_W-1:0] tagv;
    logic [NTAG-1:0][HW-1:0]    h0v, h1v;
    logic [NHALF-1:0]           used;
    logic [HW:0]                fcnt, need;
    logic [HW-1:0]              fa, fb;
    logic [PW:0]                cnt;
    logic [PW-1:0]              lk_pos, lpos, spos;
    logic                       tch;

    logic                       rm_a_en, rm_b_en, push_en;
    logic [PW-1:0]              rm_a, rm_b;
    logic [EW-1:0]              push_word;
    logic                       d_ev0v, d_ev1v;
    logic [TAG_W-1:0]           d_ev0, d_ev1;
    slot_act_e                  d_act;
    logic [HW-1:0]              d_h0, d_h1;

    // Unpack the recency list into per-field vectors.
    for (genvar g = 0; g < NTAG; g++) begin : g_unpack
        assign vld[g]  = lst[g][V_B];
        assign cmpv[g] = lst[g][C_B];
        assign tagv[g] = lst[g][T_HI:T_LO];
        assign h0v[g]  = lst[g][2*HW-1:HW];
        assign h1v[g]  = lst[g][HW-1:0];
    end

    csr_tag_match #(.NTAG(NTAG), .TW(TAG_W), .PW(PW)) u_match (
        .vld(vld), .tags(tagv), .key(lk_tag), .hit(lk_hit), .pos(lk_pos)
    );

    assign lk_cmp = lk_hit && cmpv[lk_pos];
    assign tch    = lk_en && lk_hit && !fill_en;

    // Occupancy of halves and count of live entries.
    always_comb begin
        used = '0;
        cnt  = '0;
        for (int i = 0; i < NTAG; i++) begin
            if (vld[i]) begin
                cnt          = cnt + 1'b1;
                used[h0v[i]] = 1'b1;
                if (!cmpv[i]) used[h1v[i]] = 1'b1;
            end
        end
    end

    csr_free_pick #(.NHALF(NHALF), .HW(HW)) u_free (
        .used(used), .fcnt(fcnt), .lo(fa), .lo2(fb)
    );

    assign lpos = cnt[PW-1:0] - 1'b1;
    assign spos = cnt[PW-1:0] - 2'd2;
    assign need = fill_cmp ? 1 : 2;

    // Replacement decision for a fill, or recency promotion for a lookup hit.
    always_comb begin
        rm_a_en = 1'b0; rm_a = '0;
        rm_b_en = 1'b0; rm_b = '0;
        push_en = 1'b0;
        d_ev0v  = 1'b0; d_ev0 = '0;
        d_ev1v  = 1'b0; d_ev1 = '0;
        d_act   = ACT_NONE;
        d_h0    = '0;   d_h1  = '0;
        if (fill_en) begin
            push_en = 1'b1;
            if (fcnt >= need) begin
                d_h0 = fa;
                d_h1 = fill_cmp ? '0 : fb;
            end else if (fill_cmp || !cmpv[lpos]) begin
                rm_a_en = 1'b1; rm_a = lpos;
                d_ev0v  = 1'b1; d_ev0 = tagv[lpos];
                d_h0    = h0v[lpos];
                d_h1    = fill_cmp ? '0 : h1v[lpos];
                if (fill_cmp && !cmpv[lpos]) d_act = ACT_SPLIT;
            end else if (fcnt == 1) begin
                rm_a_en = 1'b1; rm_a = lpos;
                d_ev0v  = 1'b1; d_ev0 = tagv[lpos];
                d_h0    = fa;   d_h1  = h0v[lpos];
                d_act   = ACT_MERGE;
            end else if (!cmpv[spos]) begin
                rm_a_en = 1'b1; rm_a = spos;
                d_ev0v  = 1'b1; d_ev0 = tagv[spos];
                d_h0    = h0v[spos]; d_h1 = h1v[spos];
            end else begin
                rm_a_en = 1'b1; rm_a = lpos;
                rm_b_en = 1'b1; rm_b = spos;
                d_ev0v  = 1'b1; d_ev0 = tagv[lpos];
                d_ev1v  = 1'b1; d_ev1 = tagv[spos];
                d_h0    = h0v[lpos]; d_h1 = h0v[spos];
                d_act   = ACT_MERGE;
            end
            push_word = {1'b1, fill_cmp, fill_tag, d_h0, d_h1};
        end else begin
            rm_a_en   = tch;
            rm_a      = lk_pos;
            push_en   = tch;
            push_word = lst[lk_pos];
        end
    end

    csr_order_update #(.NTAG(NTAG), .EW(EW), .PW(PW)) u_order (
        .cur(lst), .rm_a_en(rm_a_en), .rm_a(rm_a), .rm_b_en(rm_b_en), .rm_b(rm_b),
        .push_en(push_en), .push_word(push_word), .nxt(nxt_lst)
    );

    // Recency list and storage map state.
    always_ff @(posedge clk) begin
        if (!rst_n)               lst <= '0;
        else if (fill_en || tch)  lst <= nxt_lst;
    end

    // Registered fill results, held until the next fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_done <= 1'b0;
            ev0_vld   <= 1'b0; ev0_tag <= '0;
            ev1_vld   <= 1'b0; ev1_tag <= '0;
            slot_act  <= ACT_NONE;
            fill_h0   <= '0;   fill_h1 <= '0;
        end else begin
            fill_done <= fill_en;
            if (fill_en) begin
                ev0_vld  <= d_ev0v; ev0_tag <= d_ev0;
                ev1_vld  <= d_ev1v; ev1_tag <= d_ev1;
                slot_act <= d_act;
                fill_h0  <= d_h0;   fill_h1 <= d_h1;
            end
        end
    end
endmodule

// File: rtl/cmp_set_repl_chk.sv
// Protocol checks on the fill result interface of cmp_set_repl.
module cmp_set_repl_chk #(
    parameter int HW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fill_en,
    input logic          fill_done,
    input logic          ev0_vld,
    input logic          ev1_vld,
    input logic [1:0]    slot_act,
    input logic [HW-1:0] fill_h0,
    input logic [HW-1:0] fill_h1
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !fill_done);

    // R3
    fill_done_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> fill_done);

    // R3
    done_only_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> $past(fill_en));

    // R6
    split_one_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && slot_act == 2'd1) |-> (ev0_vld && !ev1_vld));

    // R8
    merge_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && slot_act == 2'd2) |-> (fill_h0 != fill_h1));

    // R5
    evict_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && ev1_vld) |-> ev0_vld);
endmodule

bind cmp_set_repl cmp_set_repl_chk #(.HW($clog2(2*NSLOT))) u_chk (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_done(fill_done),
    .ev0_vld(ev0_vld), .ev1_vld(ev1_vld), .slot_act(slot_act),
    .fill_h0(fill_h0), .fill_h1(fill_h1)
);

// File: tb/tb_cmp_set_repl.sv
// Directed bench for cmp_set_repl, NSLOT=4, TAG_W=12.
module tb_cmp_set_repl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_en = 1'b0, fill_en = 1'b0, fill_cmp = 1'b0;
    logic [11:0] lk_tag = '0, fill_tag = '0;
    logic        lk_hit, lk_cmp, fill_done, ev0_vld, ev1_vld;
    logic [11:0] ev0_tag, ev1_tag;
    logic [1:0]  slot_act;
    logic [2:0]  fill_h0, fill_h1;
    int checks = 0, errors = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    cmp_set_repl #(.NSLOT(4), .TAG_W(12)) dut (.*);

    task automatic expect_eq(string rq, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic do_lookup(string rq, int tag, int ehit, int ecmp, bit with_fill = 0,
                             int ftag = 0, bit fcmp = 0);
        @(negedge clk);
        lk_en = 1'b1; lk_tag = tag[11:0];
        if (with_fill) begin fill_en = 1'b1; fill_tag = ftag[11:0]; fill_cmp = fcmp; end
        #1;
        expect_eq(rq, "lk_hit", int'(lk_hit), ehit);
        if (ehit != 0) expect_eq(rq, "lk_cmp", int'(lk_cmp), ecmp);
        @(negedge clk);
        lk_en = 1'b0; fill_en = 1'b0;
    endtask

    // Fill and check all result fields one cycle later (h1 checked when eh1 >= 0).
    task automatic do_fill(string rq, int tag, bit c, int e0v, int e0, int e1v, int e1,
                           int eact, int eh0, int eh1);
        @(negedge clk);
        fill_en = 1'b1; fill_tag = tag[11:0]; fill_cmp = c;
        @(negedge clk);
        fill_en = 1'b0;
        expect_eq("R3", "fill_done", int'(fill_done), 1);
        expect_eq(rq, "ev0_vld", int'(ev0_vld), e0v);
        if (e0v != 0) expect_eq(rq, "ev0_tag", int'(ev0_tag), e0);
        expect_eq(rq, "ev1_vld", int'(ev1_vld), e1v);
        if (e1v != 0) expect_eq(rq, "ev1_tag", int'(ev1_tag), e1);
        expect_eq(rq, "slot_act", int'(slot_act), eact);
        expect_eq(rq, "fill_h0", int'(fill_h0), eh0);
        if (eh1 >= 0) expect_eq(rq, "fill_h1", int'(fill_h1), eh1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_eq("R1", "fill_done", int'(fill_done), 0);
        do_lookup("R1", 'h10, 0, 0);
        do_lookup("R1", 'h0, 0, 0);
    endtask

    task automatic t_free_fill();
        do_fill("R4", 'h10, 0, 0, 0, 0, 0, 0, 0, 1);
        do_fill("R4", 'h11, 0, 0, 0, 0, 0, 0, 2, 3);
        do_fill("R4", 'h12, 0, 0, 0, 0, 0, 0, 4, 5);
        do_fill("R4", 'h13, 0, 0, 0, 0, 0, 0, 6, 7);
        @(negedge clk);
        expect_eq("R3", "fill_done drop", int'(fill_done), 0);
    endtask

    task automatic t_same_status();
        do_lookup("R2", 'h10, 1, 0);
        do_fill("R5", 'h14, 0, 1, 'h11, 0, 0, 0, 2, 3);
    endtask

    task automatic t_split();
        do_fill("R6", 'h20, 1, 1, 'h12, 0, 0, 1, 4, -1);
        do_fill("R4", 'h21, 1, 0, 0, 0, 0, 0, 5, -1);
        do_fill("R5", 'h15, 0, 1, 'h13, 0, 0, 0, 6, 7);
    endtask

    task automatic t_merge_two();
        do_lookup("R2", 'h14, 1, 0);
        do_lookup("R2", 'h10, 1, 0);
        do_lookup("R2", 'h15, 1, 0);
        do_fill("R8", 'h16, 0, 1, 'h20, 1, 'h21, 2, 4, 5);
    endtask

    task automatic t_second_lru();
        do_fill("R6", 'h22, 1, 1, 'h14, 0, 0, 1, 2, -1);
        do_fill("R4", 'h23, 1, 0, 0, 0, 0, 0, 3, -1);
        do_lookup("R2", 'h15, 1, 0);
        do_lookup("R2", 'h16, 1, 0);
        do_lookup("R2", 'h10, 1, 0);
        do_lookup("R2", 'h23, 1, 1);
        do_fill("R7", 'h17, 0, 1, 'h15, 0, 0, 0, 6, 7);
        do_lookup("R7", 'h22, 1, 1);
    endtask

    task automatic t_free_merge();
        do_fill("R6", 'h24, 1, 1, 'h16, 0, 0, 1, 4, -1);
        do_lookup("R2", 'h10, 1, 0);
        do_lookup("R2", 'h17, 1, 0);
        do_fill("R9", 'h18, 0, 1, 'h23, 0, 0, 2, 5, 3);
    endtask

    task automatic t_concurrent();
        // Fill 0x25 in the same cycle as a lookup of 0x24.
        do_lookup("R10", 'h24, 1, 1, 1, 'h25, 1);
        expect_eq("R10", "ev0_tag", int'(ev0_tag), 'h22);
        // 0x24 must still be least recent.
        do_fill("R10", 'h26, 1, 1, 'h24, 0, 0, 0, 4, -1);
        do_lookup("R1", 'h22, 0, 0);
        do_lookup("R2", 'h26, 1, 1);
    endtask

    initial begin
        t_reset();
        t_free_fill();
        t_same_status();
        t_split();
        t_merge_two();
        t_second_lru();
        t_free_merge();
        t_concurrent();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule